// File: doc/BRIEF.md
# Indirect Host Window

This block gives an 8-bit host bus reach into a 32 KB internal byte space through four host-visible registers. The host first loads a 16-bit pointer one byte at a time, then moves bytes through a data port; each data-port access becomes a read or write strobe on the memory side at the folded pointer address. Reads of window registers come back on the host read bus one clock after the access.

An auto-increment mode bit advances the pointer after every data-port access. The increment is not linear across the whole space. The space holds two ring regions, and a pointer that steps off the top of one of them returns to that region's own base. A mode write with the reset bit set issues a one-cycle soft-reset pulse to the surrounding logic and clears the mode bits. It leaves the pointer where it was, so only the power-on reset returns the pointer to zero.

Top module: `host_window`

## Requirements
- R1: After the synchronous power-on reset, the pointer is 0x0000, the mode register is 0x00, `host_rdata` is 0x00, and `soft_rst`, `mem_rd` and `mem_wr` are low.
- R2: A host write to offset 5 replaces pointer bits 15:8 and keeps bits 7:0. A host write to offset 6 replaces bits 7:0 and keeps bits 15:8. The new value is in place from the next clock.
- R3: A host read of offset 4 returns the mode register. Offset 5 returns pointer bits 15:8 and offset 6 returns bits 7:0. The value appears on `host_rdata` in the clock after the access.
- R4: A data-port access (offset 7) raises `mem_wr` (write) or `mem_rd` (read) in the same clock as the host access, with `mem_addr` taken from the pointer. On a write, `mem_wdata` carries the host byte. On a read, `host_rdata` presents `mem_rdata` in the following clock, which assumes a memory with one clock of read latency.
- R5: When mode bit 1 is set, the pointer is incremented after each data-port access, and the new value is visible from the next clock. When bit 1 is clear, data-port accesses leave the pointer unchanged.
- R6: An increment that yields 0x6000 loads 0x4000 instead, and one that yields 0x8000 loads 0x6000. Every other increment is plain 16-bit (0xFFFF becomes 0x0000).
- R7: A write to offset 4 with bit 7 set pulses `soft_rst` high for exactly the following clock and clears the mode register to 0x00. The pointer is not changed. A mode write with bit 7 clear stores the written byte and raises no pulse.
- R8: `mem_addr` is the pointer masked with 0x7FFF, so a pointer at or above 0x8000 reaches the same byte as the pointer with bit 15 cleared.
- R9: Host reads of offsets 0 to 3 return 0x00. Host writes to them change neither the pointer nor the mode register.
- R10: `mem_rd` and `mem_wr` are never high together, and neither is high unless `host_sel` selects offset 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| host_sel | input | 1 | Host access strobe, one access per clock |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Window register offset |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid the clock after a read |
| mem_addr | output | 15 | Memory byte address (folded pointer) |
| mem_wdata | output | 8 | Memory write byte |
| mem_wr | output | 1 | Memory write strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Memory read byte, one clock after `mem_rd` |
| soft_rst | output | 1 | One-clock soft-reset pulse |

## Verification
The bound checker watches the pointer on every clock. It checks the increment and both ring wraps, checks that the pointer holds when auto-increment is off, that byte loads keep the other byte, that a soft reset clears the mode and keeps the pointer, and that strobes stay exclusive and quiet on non-data accesses. Some behaviour can only be seen through end-to-end host traffic, so the directed scenarios cover it. These are the read-return path through the memory's latency, the folding of high pointers into the memory address, zero reads of the low offsets, and readback of pointer bytes and mode after each kind of update.

// File: rtl/wnd_pkg.sv
package wnd_pkg;

  typedef enum logic [2:0] {
    WREG_MODE   = 3'd4,
    WREG_PTR_HI = 3'd5,
    WREG_PTR_LO = 3'd6,
    WREG_DATA   = 3'd7
  } wnd_reg_e;

  localparam int MODE_AUTOINC_BIT = 1;
  localparam int MODE_SRST_BIT    = 7;

  typedef struct packed {
    logic ld_hi;
    logic ld_lo;
    logic mode_wr;
    logic data_rd;
    logic data_wr;
    logic reg_rd;
  } wnd_ctl_t;

endpackage

// File: rtl/wnd_decode.sv
module wnd_decode
  import wnd_pkg::*;
#(
  parameter int HOST_AW = 3
) (
  input  logic               sel,
  input  logic               wr,
  input  logic [HOST_AW-1:0] addr,
  output wnd_ctl_t           ctl
);

  logic hit_mode, hit_hi, hit_lo, hit_data;

  always_comb begin
    hit_mode = (addr == HOST_AW'(WREG_MODE));
    hit_hi   = (addr == HOST_AW'(WREG_PTR_HI));
    hit_lo   = (addr == HOST_AW'(WREG_PTR_LO));
    hit_data = (addr == HOST_AW'(WREG_DATA));

    ctl.ld_hi   = sel &  wr & hit_hi;
    ctl.ld_lo   = sel &  wr & hit_lo;
    ctl.mode_wr = sel &  wr & hit_mode;
    ctl.data_wr = sel &  wr & hit_data;
    ctl.data_rd = sel & ~wr & hit_data;
    ctl.reg_rd  = sel & ~wr;
  end

endmodule

// File: rtl/wnd_mode.sv
module wnd_mode #(
  parameter int DATA_W   = 8,
  parameter int SRST_BIT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mode_o,
  output logic              srst_o
);

  logic [DATA_W-1:0] mode_q;
  logic              srst_q;
  logic              srst_req;

  assign srst_req = wr_en & wdata[SRST_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      srst_q <= 1'b0;
    end else begin
      srst_q <= srst_req;
      if (wr_en) begin
        mode_q <= srst_req ? '0 : wdata;
      end
    end
  end

  assign mode_o = mode_q;
  assign srst_o = srst_q;

endmodule

// File: rtl/wnd_pointer.sv
module wnd_pointer #(
  parameter int                             PTR_W     = 16,
  parameter int                             DATA_W    = 8,
  parameter int                             NUM_RINGS = 2,
  parameter logic [(NUM_RINGS+1)*PTR_W-1:0] RING_BOUNDS = {16'h8000, 16'h6000, 16'h4000}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_hi,
  input  logic              ld_lo,
  input  logic              step,
  input  logic [DATA_W-1:0] wdata,
  output logic [PTR_W-1:0]  ptr_o
);

  logic [PTR_W-1:0]     ptr_q;
  logic [PTR_W-1:0]     inc;
  logic [NUM_RINGS-1:0] ring_hit;
  logic [PTR_W-1:0]     ring_base [NUM_RINGS];
  logic [PTR_W-1:0]     wrap_val;
  logic [PTR_W-1:0]     step_val;

  assign inc = ptr_q + PTR_W'(1);

  genvar k;
  generate
    for (k = 0; k < NUM_RINGS; k++) begin : g_ring
      localparam logic [PTR_W-1:0] LO = RING_BOUNDS[k*PTR_W +: PTR_W];
      localparam logic [PTR_W-1:0] HI = RING_BOUNDS[(k+1)*PTR_W +: PTR_W];
      assign ring_hit[k]  = (inc == HI);
      assign ring_base[k] = ring_hit[k] ? LO : '0;
    end
  endgenerate

  always_comb begin
    wrap_val = '0;
    for (int i = 0; i < NUM_RINGS; i++) begin
      wrap_val = wrap_val | ring_base[i];
    end
    step_val = (|ring_hit) ? wrap_val : inc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (ld_hi) begin
      ptr_q[PTR_W-1 -: DATA_W] <= wdata;
    end else if (ld_lo) begin
      ptr_q[DATA_W-1:0] <= wdata;
    end else if (step) begin
      ptr_q <= step_val;
    end
  end

  assign ptr_o = ptr_q;

endmodule

// File: rtl/host_window.sv
module host_window
  import wnd_pkg::*;
#(
  parameter int                             HOST_AW   = 3,
  parameter int                             DATA_W    = 8,
  parameter int                             PTR_W     = 16,
  parameter int                             MEM_BYTES = 32768,
  parameter int                             NUM_RINGS = 2,
  parameter logic [(NUM_RINGS+1)*PTR_W-1:0] RING_BOUNDS = {16'h8000, 16'h6000, 16'h4000},
  localparam int                            MEM_AW    = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_wr,
  output logic              mem_rd,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              soft_rst
);

  wnd_ctl_t          ctl;
  logic [PTR_W-1:0]  ptr_q;
  logic [DATA_W-1:0] mode_q;
  logic              step;
  logic [DATA_W-1:0] rd_q;
  logic              from_mem_q;
  logic [DATA_W-1:0] rd_next;

  wnd_decode #(.HOST_AW(HOST_AW)) u_decode (
    .sel  (host_sel),
    .wr   (host_wr),
    .addr (host_addr),
    .ctl  (ctl)
  );

  wnd_mode #(.DATA_W(DATA_W), .SRST_BIT(MODE_SRST_BIT)) u_mode (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (ctl.mode_wr),
    .wdata  (host_wdata),
    .mode_o (mode_q),
    .srst_o (soft_rst)
  );

  assign step = (ctl.data_rd | ctl.data_wr) & mode_q[MODE_AUTOINC_BIT];

  wnd_pointer #(
    .PTR_W       (PTR_W),
    .DATA_W      (DATA_W),
    .NUM_RINGS   (NUM_RINGS),
    .RING_BOUNDS (RING_BOUNDS)
  ) u_pointer (
    .clk   (clk),
    .rst   (rst),
    .ld_hi (ctl.ld_hi),
    .ld_lo (ctl.ld_lo),
    .step  (step),
    .wdata (host_wdata),
    .ptr_o (ptr_q)
  );

  assign mem_addr  = ptr_q[MEM_AW-1:0];
  assign mem_wdata = host_wdata;
  assign mem_wr    = ctl.data_wr;
  assign mem_rd    = ctl.data_rd;

  always_comb begin
    case (host_addr)
      HOST_AW'(WREG_MODE):   rd_next = mode_q;
      HOST_AW'(WREG_PTR_HI): rd_next = ptr_q[PTR_W-1 -: DATA_W];
      HOST_AW'(WREG_PTR_LO): rd_next = ptr_q[DATA_W-1:0];
      default:               rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q       <= '0;
      from_mem_q <= 1'b0;
    end else if (ctl.reg_rd) begin
      rd_q       <= rd_next;
      from_mem_q <= ctl.data_rd;
    end
  end

  assign host_rdata = from_mem_q ? mem_rdata : rd_q;

endmodule

// File: rtl/host_window_chk.sv
module host_window_chk #(
  parameter int                             HOST_AW   = 3,
  parameter int                             DATA_W    = 8,
  parameter int                             PTR_W     = 16,
  parameter int                             NUM_RINGS = 2,
  parameter logic [(NUM_RINGS+1)*PTR_W-1:0] RING_BOUNDS = {16'h8000, 16'h6000, 16'h4000}
) (
  input logic               clk,
  input logic               rst,
  input logic               host_sel,
  input logic               host_wr,
  input logic [HOST_AW-1:0] host_addr,
  input logic [DATA_W-1:0]  host_wdata,
  input logic [DATA_W-1:0]  host_rdata,
  input logic               mem_rd,
  input logic               mem_wr,
  input logic               soft_rst,
  input logic [PTR_W-1:0]   ptr_q,
  input logic [DATA_W-1:0]  mode_q
);

  function automatic logic [PTR_W-1:0] exp_step(input logic [PTR_W-1:0] p);
    logic [PTR_W-1:0] n;
    n = p + PTR_W'(1);
    for (int i = 0; i < NUM_RINGS; i++) begin
      if (n == RING_BOUNDS[(i+1)*PTR_W +: PTR_W]) n = RING_BOUNDS[i*PTR_W +: PTR_W];
    end
    return n;
  endfunction

  logic data_acc, low_off;
  assign data_acc = host_sel && (host_addr == HOST_AW'(7));
  assign low_off  = (host_addr < HOST_AW'(4));

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst) !(mem_rd && mem_wr)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !data_acc |-> (!mem_rd && !mem_wr)); // R10
  AST_HI_LOAD: assert property (@(posedge clk) disable iff (rst) (host_sel && host_wr && host_addr == HOST_AW'(5)) |=> (ptr_q[PTR_W-1 -: DATA_W] == $past(host_wdata) && ptr_q[DATA_W-1:0] == $past(ptr_q[DATA_W-1:0]))); // R2
  AST_LO_LOAD: assert property (@(posedge clk) disable iff (rst) (host_sel && host_wr && host_addr == HOST_AW'(6)) |=> (ptr_q[DATA_W-1:0] == $past(host_wdata) && ptr_q[PTR_W-1 -: DATA_W] == $past(ptr_q[PTR_W-1 -: DATA_W]))); // R2
  AST_AUTO_STEP: assert property (@(posedge clk) disable iff (rst) (data_acc && mode_q[1]) |=> (ptr_q == exp_step($past(ptr_q)))); // R5 R6
  AST_NO_STEP: assert property (@(posedge clk) disable iff (rst) (data_acc && !mode_q[1]) |=> $stable(ptr_q)); // R5
  AST_SRST_KEEP: assert property (@(posedge clk) disable iff (rst) (host_sel && host_wr && host_addr == HOST_AW'(4) && host_wdata[7]) |=> (soft_rst && mode_q == '0 && $stable(ptr_q))); // R7
  AST_SRST_ONLY_MODE: assert property (@(posedge clk) disable iff (rst) !(host_sel && host_wr && host_addr == HOST_AW'(4) && host_wdata[7]) |=> !soft_rst); // R7
  AST_LOW_READ_ZERO: assert property (@(posedge clk) disable iff (rst) (host_sel && !host_wr && low_off) |=> (host_rdata == '0)); // R9
  AST_LOW_WRITE_IGN: assert property (@(posedge clk) disable iff (rst) (host_sel && host_wr && low_off) |=> ($stable(ptr_q) && $stable(mode_q))); // R9

endmodule

bind host_window host_window_chk #(
  .HOST_AW     (HOST_AW),
  .DATA_W      (DATA_W),
  .PTR_W       (PTR_W),
  .NUM_RINGS   (NUM_RINGS),
  .RING_BOUNDS (RING_BOUNDS)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_sel   (host_sel),
  .host_wr    (host_wr),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .host_rdata (host_rdata),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .soft_rst   (soft_rst),
  .ptr_q      (ptr_q),
  .mode_q     (mode_q)
);

// File: tb/test_host_window.sv
module test_host_window;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_sel = 1'b0;
  logic        host_wr = 1'b0;
  logic [2:0]  host_addr = 3'd0;
  logic [7:0]  host_wdata = 8'd0;
  logic [7:0]  host_rdata;
  logic [14:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_wr;
  logic        mem_rd;
  logic [7:0]  mem_rdata = 8'd0;
  logic        soft_rst;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  host_window i_host_window (
    .clk(clk), .rst(rst), .host_sel(host_sel), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wr(mem_wr),
    .mem_rd(mem_rd), .mem_rdata(mem_rdata), .soft_rst(soft_rst)
  );

  function automatic logic [7:0] mem_pat(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h3C;
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= mem_pat(mem_addr);

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  logic [7:0]  last_rd;
  logic        last_mrd, last_mwr;
  logic [14:0] last_maddr;
  logic [7:0]  last_mwd;

  task automatic acc(input bit wr, input logic [2:0] off, input logic [7:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_wr = wr; host_addr = off; host_wdata = d;
    #1;
    last_mrd = mem_rd; last_mwr = mem_wr; last_maddr = mem_addr; last_mwd = mem_wdata;
    @(negedge clk);
    host_sel = 1'b0; host_wr = 1'b0;
    last_rd = host_rdata;
  endtask

  task automatic get_ptr(output logic [15:0] p);
    acc(1'b0, 3'd5, 8'h00); p[15:8] = last_rd;
    acc(1'b0, 3'd6, 8'h00); p[7:0]  = last_rd;
  endtask

  task automatic set_ptr(input logic [15:0] p);
    acc(1'b1, 3'd5, p[15:8]);
    acc(1'b1, 3'd6, p[7:0]);
  endtask

  task automatic t_reset;
    logic [15:0] p;
    check("R1", "rdata after reset", host_rdata, 8'h00);
    check("R1", "strobes after reset", {mem_rd, mem_wr, soft_rst}, 3'b000);
    get_ptr(p);
    check("R1", "pointer after reset", p, 16'h0000);
    acc(1'b0, 3'd4, 8'h00);
    check("R1", "mode after reset", last_rd, 8'h00);
  endtask

  task automatic t_ptr_bytes;
    logic [15:0] p;
    acc(1'b1, 3'd5, 8'h12);
    get_ptr(p);
    check("R2", "hi load keeps lo", p, 16'h1200);
    acc(1'b1, 3'd6, 8'h34);
    get_ptr(p);
    check("R3", "pointer readback", p, 16'h1234);
    acc(1'b1, 3'd5, 8'hAB);
    get_ptr(p);
    check("R2", "hi replace keeps lo", p, 16'hAB34);
    acc(1'b1, 3'd6, 8'hCD);
    get_ptr(p);
    check("R2", "lo replace keeps hi", p, 16'hABCD);
  endtask

  task automatic t_data_noinc;
    logic [15:0] p;
    acc(1'b1, 3'd4, 8'h00);
    set_ptr(16'h1234);
    acc(1'b1, 3'd7, 8'h5A);
    check("R4", "write strobe", {last_mwr, last_mrd}, 2'b10);
    check("R4", "write address", last_maddr, 15'h1234);
    check("R4", "write data", last_mwd, 8'h5A);
    acc(1'b0, 3'd7, 8'h00);
    check("R4", "read strobe", {last_mwr, last_mrd}, 2'b01);
    check("R4", "read return", last_rd, mem_pat(15'h1234));
    get_ptr(p);
    check("R5", "no increment with bit1 clear", p, 16'h1234);
  endtask

  task automatic t_autoinc;
    logic [15:0] p;
    acc(1'b1, 3'd4, 8'h02);
    acc(1'b0, 3'd4, 8'h00);
    check("R7", "mode stores value", last_rd, 8'h02);
    set_ptr(16'h4100);
    for (int i = 0; i < 3; i++) begin
      acc(1'b1, 3'd7, 8'(8'h70 + i));
      check("R5", "incrementing address", last_maddr, 15'(15'h4100 + i));
    end
    acc(1'b0, 3'd7, 8'h00);
    check("R5", "read at stepped address", last_rd, mem_pat(15'h4103));
    get_ptr(p);
    check("R5", "pointer after four steps", p, 16'h4104);
  endtask

  task automatic t_wrap;
    logic [15:0] p;
    set_ptr(16'h5FFF);
    acc(1'b1, 3'd7, 8'h11);
    check("R6", "last low-ring address", last_maddr, 15'h5FFF);
    get_ptr(p);
    check("R6", "low ring wraps to 0x4000", p, 16'h4000);
    set_ptr(16'h7FFF);
    acc(1'b0, 3'd7, 8'h00);
    check("R6", "high ring read value", last_rd, mem_pat(15'h7FFF));
    get_ptr(p);
    check("R6", "high ring wraps to 0x6000", p, 16'h6000);
    set_ptr(16'hFFFF);
    acc(1'b1, 3'd7, 8'h22);
    check("R8", "0xFFFF folds to 0x7FFF", last_maddr, 15'h7FFF);
    get_ptr(p);
    check("R6", "linear 16-bit rollover", p, 16'h0000);
  endtask

  task automatic t_fold;
    acc(1'b1, 3'd4, 8'h00);
    set_ptr(16'h9234);
    acc(1'b1, 3'd7, 8'h33);
    check("R8", "folded write address", last_maddr, 15'h1234);
    acc(1'b0, 3'd7, 8'h00);
    check("R8", "folded read data", last_rd, mem_pat(15'h1234));
  endtask

  task automatic t_soft_reset;
    logic [15:0] p;
    acc(1'b1, 3'd4, 8'h02);
    set_ptr(16'h4321);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b1; host_addr = 3'd4; host_wdata = 8'h82;
    @(negedge clk);
    host_sel = 1'b0; host_wr = 1'b0;
    check("R7", "soft reset pulse high", soft_rst, 1'b1);
    @(negedge clk);
    check("R7", "soft reset pulse one clock", soft_rst, 1'b0);
    acc(1'b0, 3'd4, 8'h00);
    check("R7", "mode cleared", last_rd, 8'h00);
    get_ptr(p);
    check("R7", "pointer kept", p, 16'h4321);
    acc(1'b1, 3'd4, 8'h02);
    @(negedge clk);
    check("R7", "no pulse without bit7", soft_rst, 1'b0);
  endtask

  task automatic t_ignored;
    logic [15:0] p;
    for (int o = 0; o < 4; o++) begin
      acc(1'b1, 3'(o), 8'hFF);
      check("R10", "no strobe on low offset write", {last_mrd, last_mwr}, 2'b00);
      acc(1'b0, 3'(o), 8'h00);
      check("R9", "low offset reads zero", last_rd, 8'h00);
    end
    get_ptr(p);
    check("R9", "pointer unchanged", p, 16'h4321);
    acc(1'b0, 3'd4, 8'h00);
    check("R9", "mode unchanged", last_rd, 8'h02);
    @(negedge clk);
    host_addr = 3'd7; host_wr = 1'b1; host_sel = 1'b0;
    #1;
    check("R10", "no strobe while deselected", {mem_rd, mem_wr}, 2'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ptr_bytes();
    t_data_noinc();
    t_autoinc();
    t_wrap();
    t_fold();
    t_soft_reset();
    t_ignored();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule